// File: doc/BRIEF.md
# Fine-Grained Read-Trap Control Register Controller

This block holds a hypervisor control register whose low bits are active-low trap enables. Each bit guards EL1 reads of one system register. The block also decides what happens to every system-register access aimed at the control register itself. An access is accepted only when its decoded encoding matches the register's fixed encoding. The current exception level, the nested-virtualisation controls and the EL3 gating flags then pick one of four outcomes:

- a direct read or write of the register;
- a redirect to memory at a fixed offset;
- a trap, with its target level and syndrome class;
- an undefined-instruction result.

A second, independent query port asks whether an EL1 read of one of the guarded registers must trap to EL2, and with which syndrome class. Every result is registered and appears for exactly one cycle after the request strobe.

Top module: `rdtrap_ctl`

## Requirements
- R1: An access is acted on only when `acc_enc` = {op0[15:14], op1[13:11], CRn[10:7], CRm[6:3], op2[2:0]} equals 16'hE18A (op0=11, op1=100, CRn=0011, CRm=0001, op2=010). Any other encoding produces no outcome and does not alter the register.
- R2: A matching access with `cur_el` = 0 gives `rsp_undef`, for both reads and writes.
- R3: At `cur_el` = 1 with `nv_ctl[2]` and `nv_ctl[0]` both set, the access gives `rsp_redir` with `rsp_mem_off` = 12'h2C0. A redirected write drives `rsp_mem_wr` = 1 and puts the write data on `rsp_mem_wdata`, and the register is left unchanged.
- R4: At `cur_el` = 1, when `nv_ctl[0]` is set and `nv_ctl[2]` is clear, the access gives `rsp_trap` with `rsp_trap_el` = 2 and `rsp_cls` = 6'h18. When `nv_ctl[0]` is clear, the access gives `rsp_undef`.
- R5: At `cur_el` = 2 with `el3_present` set and `el3_fg_en` clear, the access gives `rsp_undef` if either `el3_undef_pri` or `el3_undef` is set. Otherwise it gives `rsp_trap` with `rsp_trap_el` = 3 and `rsp_cls` = 6'h18.
- R6: At `cur_el` = 2 with `el3_fg_en` set or `el3_present` clear, and at `cur_el` = 3, the access gives `rsp_direct`. A read then returns the register on `rsp_rdata`, and a write updates it.
- R7: Bits 63:3 of the register always read as zero. A written bit whose `feat_impl` bit is clear is stored as zero.
- R8: After reset every register bit reads 0 and all outcome outputs are low.
- R9: `gq_trap` is set only when four conditions all hold: `cur_el` = 1, `el2_active` is set, `feat_impl[gq_sel]` is set, and register bit `gq_sel` is 0. A bit of 1, an absent feature, `gq_sel` = 3 or any other level gives no trap.
- R10: A guarded-read trap reports `gq_cls` = 6'h18. For selector 2 with `gq_wide` set (128-bit read) it reports 6'h14.
- R11: The outcome flags `rsp_direct`, `rsp_redir`, `rsp_trap` and `rsp_undef` are at most one-hot. They appear in the cycle after the strobe's clock edge and last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_vld | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_enc | input | 16 | Decoded access encoding |
| acc_wdata | input | 64 | Write data |
| cur_el | input | 2 | Current exception level |
| nv_ctl | input | 3 | Nested-virtualisation control bits |
| el3_present | input | 1 | EL3 implemented |
| el3_fg_en | input | 1 | EL3 enable for this register group |
| el3_undef_pri | input | 1 | Undefined takes priority over the EL3 trap |
| el3_undef | input | 1 | Undefined instead of the EL3 trap |
| el2_active | input | 1 | EL2 implemented and enabled in the current security state |
| feat_impl | input | 3 | Per-bit feature implemented |
| gq_vld | input | 1 | Guarded-read query strobe |
| gq_sel | input | 2 | Guarded register selector |
| gq_wide | input | 1 | 128-bit guarded read |
| rsp_direct | output | 1 | Direct register access outcome |
| rsp_redir | output | 1 | Memory redirect outcome |
| rsp_trap | output | 1 | Trap outcome |
| rsp_undef | output | 1 | Undefined outcome |
| rsp_rdata | output | 64 | Read data on a direct read |
| rsp_mem_wr | output | 1 | Redirected access is a write |
| rsp_mem_off | output | 12 | Redirect memory offset |
| rsp_mem_wdata | output | 64 | Redirected write data |
| rsp_trap_el | output | 2 | Trap target level |
| rsp_cls | output | 6 | Trap syndrome class |
| gq_trap | output | 1 | Guarded read traps to EL2 |
| gq_cls | output | 6 | Guarded-read syndrome class |

## Verification
A corrupted trap bit is invisible at the access port until the next query or direct read. Each test therefore writes the register at EL3 and then reads it straight back, so a stored bit that went wrong shows within two accesses. A wrong branch in the decision tree shows as the wrong one-hot flag, or a wrong target level or class, on the cycle after the strobe. A stale flag shows as a nonzero outcome one cycle later.

// File: rtl/rdtrap_pkg.sv
package rdtrap_pkg;
   typedef struct packed {
      logic direct;
      logic redir;
      logic trap;
      logic undef;
   } outcome_t;

   localparam int CLS_A64  = 'h18;
   localparam int CLS_A128 = 'h14;
   localparam logic [1:0] LVL0 = 2'd0;
   localparam logic [1:0] LVL1 = 2'd1;
   localparam logic [1:0] LVL2 = 2'd2;
   localparam logic [1:0] LVL3 = 2'd3;
endpackage

// File: rtl/rdtrap_access_dec.sv
module rdtrap_access_dec
   import rdtrap_pkg::*;
#(
   parameter int                ENC_W     = 16,
   parameter logic [ENC_W-1:0]  MATCH_ENC = 16'hE18A,
   parameter int                CLS_W     = 6
) (
   input  logic              acc_vld,
   input  logic [ENC_W-1:0]  acc_enc,
   input  logic [1:0]        cur_el,
   input  logic [2:0]        nv_ctl,
   input  logic              el3_present,
   input  logic              el3_fg_en,
   input  logic              el3_undef_pri,
   input  logic              el3_undef,
   output outcome_t          oc,
   output logic [1:0]        trap_el,
   output logic [CLS_W-1:0]  trap_cls
);
   localparam logic [CLS_W-1:0] CLS64 = CLS_W'(CLS_A64);

   logic hit;
   assign hit = acc_vld && (acc_enc == MATCH_ENC);

   always_comb begin
      oc       = '0;
      trap_el  = LVL0;
      trap_cls = '0;
      if (hit) begin
         case (cur_el)
            LVL0: oc.undef = 1'b1;
            LVL1: begin
               if (nv_ctl[2] && nv_ctl[0]) begin
                  oc.redir = 1'b1;
               end else if (nv_ctl[0]) begin
                  oc.trap  = 1'b1;
                  trap_el  = LVL2;
                  trap_cls = CLS64;
               end else begin
                  oc.undef = 1'b1;
               end
            end
            LVL2: begin
               if (el3_present && !el3_fg_en) begin
                  if (el3_undef_pri || el3_undef) begin
                     oc.undef = 1'b1;
                  end else begin
                     oc.trap  = 1'b1;
                     trap_el  = LVL3;
                     trap_cls = CLS64;
                  end
               end else begin
                  oc.direct = 1'b1;
               end
            end
            default: oc.direct = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/rdtrap_bits.sv
module rdtrap_bits #(
   parameter int NUM_GUARD = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [NUM_GUARD-1:0] wbits,
   input  logic [NUM_GUARD-1:0] feat_impl,
   output logic [NUM_GUARD-1:0] bits
);
   for (genvar g = 0; g < NUM_GUARD; g++) begin : g_bit
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     q <= 1'b0;
         else if (wr_en) q <= wbits[g] & feat_impl[g];
      end
      assign bits[g] = q & feat_impl[g];
   end
endmodule

// File: rtl/rdtrap_guard.sv
module rdtrap_guard
   import rdtrap_pkg::*;
#(
   parameter int                   NUM_GUARD = 3,
   parameter int                   SEL_W     = 2,
   parameter logic [NUM_GUARD-1:0] WIDE_MASK = 3'b100,
   parameter int                   CLS_W     = 6
) (
   input  logic                 q_vld,
   input  logic [SEL_W-1:0]     q_sel,
   input  logic                 q_wide,
   input  logic [1:0]           cur_el,
   input  logic                 el2_active,
   input  logic [NUM_GUARD-1:0] bits,
   input  logic [NUM_GUARD-1:0] feat_impl,
   output logic                 trap,
   output logic [CLS_W-1:0]     cls
);
   logic [CLS_W-1:0]     cls_arr [NUM_GUARD];
   logic [NUM_GUARD-1:0] arm;

   for (genvar g = 0; g < NUM_GUARD; g++) begin : g_grd
      assign arm[g] = feat_impl[g] & ~bits[g];
      if (WIDE_MASK[g]) begin : g_wide
         assign cls_arr[g] = q_wide ? CLS_W'(CLS_A128) : CLS_W'(CLS_A64);
      end else begin : g_narrow
         assign cls_arr[g] = CLS_W'(CLS_A64);
      end
   end

   always_comb begin
      trap = 1'b0;
      cls  = '0;
      if (q_vld && cur_el == LVL1 && el2_active) begin
         for (int g = 0; g < NUM_GUARD; g++) begin
            if (int'(q_sel) == g && arm[g]) begin
               trap = 1'b1;
               cls  = cls_arr[g];
            end
         end
      end
   end
endmodule

// File: rtl/rdtrap_ctl.sv
module rdtrap_ctl
   import rdtrap_pkg::*;
#(
   parameter int                   REG_W     = 64,
   parameter int                   NUM_GUARD = 3,
   parameter int                   ENC_W     = 16,
   parameter logic [ENC_W-1:0]     MATCH_ENC = 16'hE18A,
   parameter int                   OFF_W     = 12,
   parameter logic [OFF_W-1:0]     MEM_OFF   = 12'h2C0,
   parameter int                   CLS_W     = 6,
   parameter logic [NUM_GUARD-1:0] WIDE_MASK = 3'b100,
   localparam int                  SEL_W     = (NUM_GUARD > 1) ? $clog2(NUM_GUARD + 1) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 acc_vld,
   input  logic                 acc_wr,
   input  logic [ENC_W-1:0]     acc_enc,
   input  logic [REG_W-1:0]     acc_wdata,
   input  logic [1:0]           cur_el,
   input  logic [2:0]           nv_ctl,
   input  logic                 el3_present,
   input  logic                 el3_fg_en,
   input  logic                 el3_undef_pri,
   input  logic                 el3_undef,
   input  logic                 el2_active,
   input  logic [NUM_GUARD-1:0] feat_impl,
   input  logic                 gq_vld,
   input  logic [SEL_W-1:0]     gq_sel,
   input  logic                 gq_wide,
   output logic                 rsp_direct,
   output logic                 rsp_redir,
   output logic                 rsp_trap,
   output logic                 rsp_undef,
   output logic [REG_W-1:0]     rsp_rdata,
   output logic                 rsp_mem_wr,
   output logic [OFF_W-1:0]     rsp_mem_off,
   output logic [REG_W-1:0]     rsp_mem_wdata,
   output logic [1:0]           rsp_trap_el,
   output logic [CLS_W-1:0]     rsp_cls,
   output logic                 gq_trap,
   output logic [CLS_W-1:0]     gq_cls
);
   if (NUM_GUARD < 1 || NUM_GUARD >= REG_W) begin : g_bad_guard
      initial $fatal(1, "rdtrap_ctl: NUM_GUARD out of range");
   end
   if (CLS_W < 6) begin : g_bad_cls
      initial $fatal(1, "rdtrap_ctl: CLS_W too narrow");
   end

   outcome_t             oc;
   logic [1:0]           dec_el;
   logic [CLS_W-1:0]     dec_cls;
   logic [NUM_GUARD-1:0] bits;
   logic                 wr_en;
   logic                 grd_trap;
   logic [CLS_W-1:0]     grd_cls;
   logic [REG_W-1:0]     reg_view;

   rdtrap_access_dec #(
      .ENC_W(ENC_W), .MATCH_ENC(MATCH_ENC), .CLS_W(CLS_W)
   ) u_dec (
      .acc_vld(acc_vld), .acc_enc(acc_enc), .cur_el(cur_el), .nv_ctl(nv_ctl),
      .el3_present(el3_present), .el3_fg_en(el3_fg_en),
      .el3_undef_pri(el3_undef_pri), .el3_undef(el3_undef),
      .oc(oc), .trap_el(dec_el), .trap_cls(dec_cls)
   );

   assign wr_en = oc.direct & acc_wr;

   rdtrap_bits #(.NUM_GUARD(NUM_GUARD)) u_bits (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
      .wbits(acc_wdata[NUM_GUARD-1:0]), .feat_impl(feat_impl), .bits(bits)
   );

   rdtrap_guard #(
      .NUM_GUARD(NUM_GUARD), .SEL_W(SEL_W), .WIDE_MASK(WIDE_MASK), .CLS_W(CLS_W)
   ) u_grd (
      .q_vld(gq_vld), .q_sel(gq_sel), .q_wide(gq_wide), .cur_el(cur_el),
      .el2_active(el2_active), .bits(bits), .feat_impl(feat_impl),
      .trap(grd_trap), .cls(grd_cls)
   );

   assign reg_view = {{(REG_W-NUM_GUARD){1'b0}}, bits};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_direct    <= 1'b0;
         rsp_redir     <= 1'b0;
         rsp_trap      <= 1'b0;
         rsp_undef     <= 1'b0;
         rsp_rdata     <= '0;
         rsp_mem_wr    <= 1'b0;
         rsp_mem_off   <= '0;
         rsp_mem_wdata <= '0;
         rsp_trap_el   <= '0;
         rsp_cls       <= '0;
         gq_trap       <= 1'b0;
         gq_cls        <= '0;
      end else begin
         rsp_direct    <= oc.direct;
         rsp_redir     <= oc.redir;
         rsp_trap      <= oc.trap;
         rsp_undef     <= oc.undef;
         rsp_rdata     <= (oc.direct && !acc_wr) ? reg_view : '0;
         rsp_mem_wr    <= oc.redir & acc_wr;
         rsp_mem_off   <= oc.redir ? MEM_OFF : '0;
         rsp_mem_wdata <= (oc.redir && acc_wr) ? acc_wdata : '0;
         rsp_trap_el   <= dec_el;
         rsp_cls       <= dec_cls;
         gq_trap       <= grd_trap;
         gq_cls        <= grd_cls;
      end
   end
endmodule

// File: rtl/rdtrap_ctl_chk.sv
module rdtrap_ctl_chk #(
   parameter int               REG_W     = 64,
   parameter int               NUM_GUARD = 3,
   parameter int               ENC_W     = 16,
   parameter logic [ENC_W-1:0] MATCH_ENC = 16'hE18A,
   parameter int               OFF_W     = 12,
   parameter logic [OFF_W-1:0] MEM_OFF   = 12'h2C0,
   parameter int               CLS_W     = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acc_vld,
   input logic [ENC_W-1:0] acc_enc,
   input logic [1:0]       cur_el,
   input logic             el2_active,
   input logic             rsp_direct,
   input logic             rsp_redir,
   input logic             rsp_trap,
   input logic             rsp_undef,
   input logic [REG_W-1:0] rsp_rdata,
   input logic [OFF_W-1:0] rsp_mem_off,
   input logic             gq_trap,
   input logic [CLS_W-1:0] gq_cls
);
   logic any_out;
   assign any_out = rsp_direct | rsp_redir | rsp_trap | rsp_undef;

   // R11
   onehot_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_direct, rsp_redir, rsp_trap, rsp_undef}));

   // R11
   strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_out |-> $past(acc_vld));

   // R1
   foreign_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && acc_enc != MATCH_ENC) |=> !any_out);

   // R2
   lvl0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && acc_enc == MATCH_ENC && cur_el == 2'd0) |=> rsp_undef);

   // R3
   redir_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_redir |-> rsp_mem_off == MEM_OFF);

   // R7
   resv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_direct |-> rsp_rdata[REG_W-1:NUM_GUARD] == '0);

   // R9
   guard_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gq_trap |-> ($past(cur_el) == 2'd1 && $past(el2_active)));

   // R10
   guard_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gq_trap |-> (gq_cls == CLS_W'('h18) || gq_cls == CLS_W'('h14)));
endmodule

bind rdtrap_ctl rdtrap_ctl_chk #(
   .REG_W(REG_W), .NUM_GUARD(NUM_GUARD), .ENC_W(ENC_W), .MATCH_ENC(MATCH_ENC),
   .OFF_W(OFF_W), .MEM_OFF(MEM_OFF), .CLS_W(CLS_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_enc(acc_enc),
   .cur_el(cur_el), .el2_active(el2_active),
   .rsp_direct(rsp_direct), .rsp_redir(rsp_redir), .rsp_trap(rsp_trap),
   .rsp_undef(rsp_undef), .rsp_rdata(rsp_rdata), .rsp_mem_off(rsp_mem_off),
   .gq_trap(gq_trap), .gq_cls(gq_cls)
);

// File: tb/rdtrap_ctl_tb.sv
`timescale 1ns/1ps
module rdtrap_ctl_tb;
   localparam logic [15:0] ENC_OK = 16'hE18A;
   localparam logic [3:0]  O_DIR = 4'b1000, O_RED = 4'b0100, O_TRP = 4'b0010,
                           O_UND = 4'b0001, O_NONE = 4'b0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_vld = 1'b0, acc_wr = 1'b0;
   logic [15:0] acc_enc = '0;
   logic [63:0] acc_wdata = '0;
   logic [1:0]  cur_el = '0;
   logic [2:0]  nv_ctl = '0;
   logic        el3_present = 1'b0, el3_fg_en = 1'b0, el3_undef_pri = 1'b0, el3_undef = 1'b0;
   logic        el2_active = 1'b1;
   logic [2:0]  feat_impl = 3'b111;
   logic        gq_vld = 1'b0;
   logic [1:0]  gq_sel = '0;
   logic        gq_wide = 1'b0;
   logic        rsp_direct, rsp_redir, rsp_trap, rsp_undef, rsp_mem_wr, gq_trap;
   logic [63:0] rsp_rdata, rsp_mem_wdata;
   logic [11:0] rsp_mem_off;
   logic [1:0]  rsp_trap_el;
   logic [5:0]  rsp_cls, gq_cls;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [3:0]  s_oc;
   logic [63:0] s_rdata, s_mwdata;
   logic        s_mwr;
   logic [11:0] s_off;
   logic [1:0]  s_tel;
   logic [5:0]  s_cls;

   always #2 clk = ~clk;

   rdtrap_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_enc(acc_enc),
      .acc_wdata(acc_wdata), .cur_el(cur_el), .nv_ctl(nv_ctl), .el3_present(el3_present),
      .el3_fg_en(el3_fg_en), .el3_undef_pri(el3_undef_pri), .el3_undef(el3_undef),
      .el2_active(el2_active), .feat_impl(feat_impl), .gq_vld(gq_vld), .gq_sel(gq_sel),
      .gq_wide(gq_wide), .rsp_direct(rsp_direct), .rsp_redir(rsp_redir), .rsp_trap(rsp_trap),
      .rsp_undef(rsp_undef), .rsp_rdata(rsp_rdata), .rsp_mem_wr(rsp_mem_wr),
      .rsp_mem_off(rsp_mem_off), .rsp_mem_wdata(rsp_mem_wdata), .rsp_trap_el(rsp_trap_el),
      .rsp_cls(rsp_cls), .gq_trap(gq_trap), .gq_cls(gq_cls)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic access(input logic wr, input logic [15:0] enc, input logic [63:0] wd,
                         input logic [1:0] el);
      @(negedge clk);
      acc_vld = 1'b1; acc_wr = wr; acc_enc = enc; acc_wdata = wd; cur_el = el;
      @(negedge clk);
      s_oc     = {rsp_direct, rsp_redir, rsp_trap, rsp_undef};
      s_rdata  = rsp_rdata;
      s_mwr    = rsp_mem_wr;
      s_mwdata = rsp_mem_wdata;
      s_off    = rsp_mem_off;
      s_tel    = rsp_trap_el;
      s_cls    = rsp_cls;
      acc_vld = 1'b0; acc_wr = 1'b0; acc_wdata = '0;
   endtask

   task automatic rd_el3(output logic [63:0] v);
      logic [1:0] keep_el = cur_el;
      access(1'b0, ENC_OK, '0, 2'd3);
      v = s_rdata;
      cur_el = keep_el;
   endtask

   task automatic query(input logic [1:0] sel, input logic wide, input logic [1:0] el);
      @(negedge clk);
      gq_vld = 1'b1; gq_sel = sel; gq_wide = wide; cur_el = el;
      @(negedge clk);
      s_oc  = {3'b000, gq_trap};
      s_cls = gq_cls;
      gq_vld = 1'b0;
   endtask

   task automatic t_reset();
      logic [63:0] v;
      chk("R8 idle outcomes", {rsp_direct, rsp_redir, rsp_trap, rsp_undef}, O_NONE);
      rd_el3(v);
      chk("R8 reset value", v, 64'h0);
   endtask

   task automatic t_encoding();
      logic [63:0] v;
      access(1'b1, 16'hE18B, 64'h7, 2'd3);
      chk("R1 foreign enc outcome", s_oc, O_NONE);
      access(1'b1, 16'h618A, 64'h7, 2'd3);
      chk("R1 foreign op0 outcome", s_oc, O_NONE);
      rd_el3(v);
      chk("R1 register untouched", v, 64'h0);
   endtask

   task automatic t_el0();
      access(1'b0, ENC_OK, '0, 2'd0);
      chk("R2 read at level 0", s_oc, O_UND);
      access(1'b1, ENC_OK, 64'h5, 2'd0);
      chk("R2 write at level 0", s_oc, O_UND);
   endtask

   task automatic t_el1();
      logic [63:0] v;
      nv_ctl = 3'b101;
      access(1'b1, ENC_OK, 64'hDEAD_0000_0000_0007, 2'd1);
      chk("R3 redirect outcome", s_oc, O_RED);
      chk("R3 redirect offset", s_off, 12'h2C0);
      chk("R3 redirect write flag", s_mwr, 1'b1);
      chk("R3 redirect data", s_mwdata, 64'hDEAD_0000_0000_0007);
      rd_el3(v);
      chk("R3 register unchanged", v, 64'h0);
      nv_ctl = 3'b111;
      access(1'b0, ENC_OK, '0, 2'd1);
      chk("R3 redirect read", {s_oc, 4'(s_mwr)}, {O_RED, 4'h0});
      nv_ctl = 3'b001;
      access(1'b0, ENC_OK, '0, 2'd1);
      chk("R4 trap to level 2", {s_oc, 2'b00, s_tel, 2'b00, s_cls}, {O_TRP, 2'b00, 2'd2, 2'b00, 6'h18});
      nv_ctl = 3'b011;
      access(1'b1, ENC_OK, 64'h7, 2'd1);
      chk("R4 trap write", s_oc, O_TRP);
      nv_ctl = 3'b100;
      access(1'b0, ENC_OK, '0, 2'd1);
      chk("R4 undef without bit0", s_oc, O_UND);
      nv_ctl = 3'b000;
      access(1'b0, ENC_OK, '0, 2'd1);
      chk("R4 undef no bits", s_oc, O_UND);
      rd_el3(v);
      chk("R4 register unchanged", v, 64'h0);
   endtask

   task automatic t_el2();
      logic [63:0] v;
      el3_present = 1'b1; el3_fg_en = 1'b0;
      el3_undef_pri = 1'b1; el3_undef = 1'b0;
      access(1'b0, ENC_OK, '0, 2'd2);
      chk("R5 undef priority", s_oc, O_UND);
      el3_undef_pri = 1'b0; el3_undef = 1'b1;
      access(1'b1, ENC_OK, 64'h7, 2'd2);
      chk("R5 undef flag", s_oc, O_UND);
      el3_undef = 1'b0;
      access(1'b0, ENC_OK, '0, 2'd2);
      chk("R5 trap to level 3", {s_oc, 2'b00, s_tel, 2'b00, s_cls}, {O_TRP, 2'b00, 2'd3, 2'b00, 6'h18});
      el3_fg_en = 1'b1;
      access(1'b1, ENC_OK, 64'h6, 2'd2);
      chk("R6 direct write enabled", s_oc, O_DIR);
      access(1'b0, ENC_OK, '0, 2'd2);
      chk("R6 direct read enabled", s_rdata, 64'h6);
      el3_present = 1'b0; el3_fg_en = 1'b0;
      access(1'b1, ENC_OK, 64'h1, 2'd2);
      chk("R6 direct write no level 3", s_oc, O_DIR);
      rd_el3(v);
      chk("R6 level 3 read", v, 64'h1);
   endtask

   task automatic t_resv();
      logic [63:0] v;
      access(1'b1, ENC_OK, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3);
      rd_el3(v);
      chk("R7 reserved bits zero", v, 64'h7);
      feat_impl = 3'b101;
      access(1'b1, ENC_OK, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3);
      rd_el3(v);
      chk("R7 absent feature bit", v, 64'h5);
      feat_impl = 3'b111;
   endtask

   task automatic t_guard();
      access(1'b1, ENC_OK, 64'h0, 2'd3);
      el2_active = 1'b1;
      query(2'd0, 1'b0, 2'd1);
      chk("R9 sel0 traps", {s_oc[0], s_cls}, {1'b1, 6'h18});
      query(2'd1, 1'b0, 2'd1);
      chk("R9 sel1 traps", {s_oc[0], s_cls}, {1'b1, 6'h18});
      query(2'd2, 1'b1, 2'd1);
      chk("R10 wide class", {s_oc[0], s_cls}, {1'b1, 6'h14});
      query(2'd2, 1'b0, 2'd1);
      chk("R10 narrow class", {s_oc[0], s_cls}, {1'b1, 6'h18});
      query(2'd3, 1'b0, 2'd1);
      chk("R9 unused selector", s_oc[0], 1'b0);
      query(2'd1, 1'b0, 2'd2);
      chk("R9 other level", s_oc[0], 1'b0);
      el2_active = 1'b0;
      query(2'd1, 1'b0, 2'd1);
      chk("R9 level 2 inactive", s_oc[0], 1'b0);
      el2_active = 1'b1;
      access(1'b1, ENC_OK, 64'h5, 2'd3);
      query(2'd0, 1'b0, 2'd1);
      chk("R9 bit set no trap", s_oc[0], 1'b0);
      query(2'd1, 1'b0, 2'd1);
      chk("R9 bit clear traps", s_oc[0], 1'b1);
      feat_impl = 3'b101;
      query(2'd1, 1'b0, 2'd1);
      chk("R9 absent feature", s_oc[0], 1'b0);
      feat_impl = 3'b111;
   endtask

   task automatic t_pulse();
      access(1'b0, ENC_OK, '0, 2'd0);
      chk("R11 outcome present", s_oc, O_UND);
      @(negedge clk);
      chk("R11 one cycle", {rsp_direct, rsp_redir, rsp_trap, rsp_undef}, O_NONE);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_encoding();
      t_el0();
      t_el1();
      t_el2();
      t_resv();
      t_guard();
      t_pulse();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule